// File: doc/BRIEF.md
# Split-Converter Background Gain Calibrator

This block sits behind two half-size cyclic converters that sample the same analog input. Each conversion delivers a reconstructed code from each half together with the comparator decision sequence that produced it. The block emits the mean of the two codes as the final result. It also uses the disagreement between the two codes to adjust a gain estimate for each half while normal conversions continue. No known test input is needed. The updated estimates go to the logic that rebuilds each half's decision-weight table.

The difference `code_b - code_a` is modelled as each half's error coefficient times the fractional error of its gain estimate. That coefficient is a weighted sum of the half's decisions, where cycle k carries weight k·(1/G)^k. The block uses sign-sign LMS. Each estimate moves by one power-of-two step, in the direction given by the sign of the difference and the sign of that half's coefficient, and is clamped to the range 1.5 to 2.0. An error is only visible when the two halves make different decisions. For that reason a small per-half sequence generator picks a different residue mode for each half on every conversion. A run monitor reports convergence once the disagreement has stayed small long enough.

Top module: `split_gain_cal`

## Requirements
- R1: One cycle after a cycle with `conv_vld` high, `out_vld` is high and `code_out` equals floor((code_a + code_b)/2), with both codes taken as two's complement. In any other cycle `out_vld` is low.
- R2: A decision field holds NCYC 2-bit entries, with cycle k (1-based) in bits [2k-1:2k-2]. Code 01 means +1, code 11 means -1, and codes 00 and 10 mean 0. The coefficient of a half is the sum of d_k·w_k, where w_k = k·p_k, p_0 = 4096, p_k = floor(p_{k-1}·inv/4096) and inv = floor(2^24/G_NOM).
- R3: On each conversion, gain_b moves by +step·sgn(code_b − code_a)·sgn(coef_b), where sgn(0) = 0.
- R4: On each conversion, gain_a moves by −step·sgn(code_b − code_a)·sgn(coef_a).
- R5: Gains are 24-bit unsigned with 22 fraction bits, and step = 2^`mu_shift` LSBs.
- R6: After every update, each gain is clamped into [0x600000, 0x800000], that is [1.5, 2.0].
- R7: After reset the gains equal the parameters GA_INIT and GB_INIT. They do not change in any cycle without `conv_vld`.
- R8: The mode outputs reset to `mode_a`=01 and `mode_b`=10. Each generator advances once per conversion by s → {s[0], s[1]^s[0]}. If the two states are equal, `mode_b` shows the bitwise inverse of its state, so the two mode outputs always differ.
- R9: `converged` goes high after CONV_RUN consecutive conversions with |code_b − code_a| < `conv_thr`, and stays high while that holds. It clears on the first conversion that violates it.
- R10: During and after reset, `out_vld` and `converged` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_vld | input | 1 | Both halves present a conversion this cycle |
| code_a | input | CW | Reconstructed code of half A, two's complement |
| code_b | input | CW | Reconstructed code of half B, two's complement |
| dec_a | input | 2·NCYC | Decision sequence of half A |
| dec_b | input | 2·NCYC | Decision sequence of half B |
| mu_shift | input | 5 | Step size exponent |
| conv_thr | input | CW | Disagreement threshold for convergence |
| code_out | output | CW | Averaged output code |
| out_vld | output | 1 | Output code and gains updated |
| gain_a | output | 24 | Gain estimate of half A |
| gain_b | output | 24 | Gain estimate of half B |
| mode_a | output | 2 | Residue mode for half A's next conversion |
| mode_b | output | 2 | Residue mode for half B's next conversion |
| converged | output | 1 | Disagreement has stayed below threshold |

## Verification
The assertions assume three things about the inputs. `conv_vld` is held low throughout reset. `mu_shift` stays at 23 or below, so that a single step is smaller than the 24-bit gain word. The two input codes are CW-bit values, so their difference always fits in CW+1 bits. The stimulus keeps `mu_shift` between 10 and 21 and draws codes well inside the signed range. It sweeps every pair of decision encodings for a three-cycle configuration against negative, zero and positive differences, so every sign combination and the reserved decision code all reach the update logic.

// File: rtl/splitcal_pkg.sv
// Shared constants and elaboration-time helpers for the split calibrator.
// Assumes G_NOM is given in Q.12 and lies well above 1.0.
package splitcal_pkg;
    localparam int WF = 12;

    // Decision code to signed value: 01 -> +1, 11 -> -1, else 0.
    function automatic int dec_val(input logic [1:0] c);
        return (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
    endfunction

    // Weight k * (1/G)^k in Q.12, computed by repeated fixed-point multiply.
    function automatic int cyc_weight(input int k, input int gnom_q);
        longint p;
        longint inv;
        p   = longint'(1) << WF;
        inv = (longint'(1) << (2 * WF)) / longint'(gnom_q);
        for (int i = 0; i < k; i++) p = (p * inv) >>> WF;
        return int'(longint'(k) * p);
    endfunction
endpackage

// File: rtl/sdk_accum.sv
// Error coefficient of one converter half: the sum of its decisions, each
// scaled by a per-cycle weight computed at elaboration.
// Assumes decisions are stable in the cycle they are used; purely combinational.
module sdk_accum #(
    parameter int NCYC  = 6,
    parameter int G_NOM = 7864,
    parameter int SW    = 24
) (
    input  logic [2*NCYC-1:0]    dec,
    output logic signed [SW-1:0] coef
);
    import splitcal_pkg::*;

    logic signed [SW-1:0] term [NCYC];

    for (genvar k = 0; k < NCYC; k++) begin : g_term
        localparam int WK = cyc_weight(k + 1, G_NOM);
        // Map one decision entry to +W, -W or zero.
        always_comb begin
            unique case (dec[2*k +: 2])
                2'b01:   term[k] = SW'(WK);
                2'b11:   term[k] = -SW'(WK);
                default: term[k] = '0;
            endcase
        end
    end

    // Add up the weighted decisions.
    always_comb begin
        coef = '0;
        for (int k = 0; k < NCYC; k++) coef = coef + term[k];
    end
endmodule

// File: rtl/gain_track.sv
// One gain estimate with a sign-sign LMS update and clamping.
// POL = +1 moves the gain with sgn(err)*sgn(coef), POL = -1 moves against it.
// Assumes step is smaller than 2^GW and upd is low during reset.
module gain_track #(
    parameter int          GW   = 24,
    parameter int          SW   = 24,
    parameter logic [23:0] INIT = 24'h7AE148,
    parameter logic [23:0] GMIN = 24'h600000,
    parameter logic [23:0] GMAX = 24'h800000,
    parameter int          POL  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic signed [1:0]    err_sgn,
    input  logic signed [SW-1:0] coef,
    input  logic [GW:0]          step,
    output logic [GW-1:0]        gain
);
    logic signed [1:0] coef_sgn;
    logic              go_up;
    logic              go_dn;
    logic [GW+1:0]     sum_up;
    logic [GW+1:0]     sum_dn;
    logic [GW-1:0]     gain_nxt;
    logic [GW-1:0]     gain_q;

    // Sign of the error coefficient.
    always_comb begin
        if (coef > 0)      coef_sgn = 2'sd1;
        else if (coef < 0) coef_sgn = -2'sd1;
        else               coef_sgn = 2'sd0;
    end

    // Decide direction from the two signs and the polarity.
    always_comb begin
        go_up = 1'b0;
        go_dn = 1'b0;
        if (err_sgn != 0 && coef_sgn != 0) begin
            if ((err_sgn == coef_sgn) == (POL > 0)) go_up = 1'b1;
            else                                    go_dn = 1'b1;
        end
    end

    // Candidate values and clamp into [GMIN, GMAX].
    always_comb begin
        sum_up = {2'b00, gain_q} + {1'b0, step};
        sum_dn = {2'b00, gain_q} - {1'b0, step};
        gain_nxt = gain_q;
        if (go_up) begin
            gain_nxt = (sum_up > {2'b00, GMAX}) ? GMAX : sum_up[GW-1:0];
        end else if (go_dn) begin
            if (sum_dn[GW+1] || sum_dn < {2'b00, GMIN}) gain_nxt = GMIN;
            else                                         gain_nxt = sum_dn[GW-1:0];
        end
    end

    // Gain register: reset value from parameter, updated once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)   gain_q <= INIT;
        else if (upd) gain_q <= gain_nxt;
    end

    assign gain = gain_q;

    a_r6_gain_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q >= GMIN) && (gain_q <= GMAX));

    a_r7_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(gain_q));

    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (((gain_q >= $past(gain_q)) ? ({1'b0, gain_q} - {1'b0, $past(gain_q)})
                                            : ({1'b0, $past(gain_q)} - {1'b0, gain_q}))
                 <= $past(step)));
endmodule

// File: rtl/mode_gen.sv
// Residue-mode selection for both halves: one 2-bit LFSR per half, advanced
// once per conversion, with half B's output inverted whenever the two agree.
// Assumes upd is one pulse per conversion.
module mode_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    output logic [1:0] mode_a,
    output logic [1:0] mode_b
);
    logic [1:0] st_a;
    logic [1:0] st_b;

    // Advance both generators on each conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_a <= 2'b01;
            st_b <= 2'b10;
        end else if (upd) begin
            st_a <= {st_a[0], st_a[1] ^ st_a[0]};
            st_b <= {st_b[0], st_b[1] ^ st_b[0]};
        end
    end

    // Force distinct modes on the two halves.
    always_comb begin
        mode_a = st_a;
        mode_b = (st_b == st_a) ? ~st_b : st_b;
    end

    a_r8_modes_differ: assert property (@(posedge clk) disable iff (!rst_n)
        mode_a != mode_b);

    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(mode_a));
endmodule

// File: rtl/run_monitor.sv
// Convergence flag: counts consecutive conversions whose disagreement
// magnitude is below the threshold; any violation restarts the count.
// Assumes diff is the CW+1-bit difference of two CW-bit codes.
module run_monitor #(
    parameter int CW  = 16,
    parameter int RUN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic signed [CW:0] diff,
    input  logic [CW-1:0]     thr,
    output logic              converged
);
    localparam int CNTW = $clog2(RUN + 1);

    logic [CW:0]   mag;
    logic          below;
    logic [CNTW-1:0] cnt;

    // Magnitude of the disagreement and comparison with the threshold.
    always_comb begin
        mag   = diff[CW] ? (~diff + 1'b1) : diff;
        below = mag < {1'b0, thr};
    end

    // Saturating run counter of in-threshold conversions.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (upd) begin
            if (!below)        cnt <= '0;
            else if (cnt != CNTW'(RUN)) cnt <= cnt + 1'b1;
        end
    end

    assign converged = (cnt == CNTW'(RUN));

    a_r9_clear_on_violation: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !below) |=> !converged);

    a_r9_rise_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(converged) |-> $past(upd && below));
endmodule

// File: rtl/split_gain_cal.sv
// Top of the split-converter calibrator. Averages the two half codes into
// the output, derives each half's error coefficient from its decisions,
// and runs sign-sign LMS on both gain estimates from the code difference.
// Assumes conv_vld is low during reset and mu_shift <= 23.
module split_gain_cal #(
    parameter int          CW       = 16,
    parameter int          NCYC     = 6,
    parameter int          G_NOM    = 7864,
    parameter logic [23:0] GA_INIT  = 24'h7AE148,
    parameter logic [23:0] GB_INIT  = 24'h7AE148,
    parameter int          CONV_RUN = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_vld,
    input  logic signed [CW-1:0]   code_a,
    input  logic signed [CW-1:0]   code_b,
    input  logic [2*NCYC-1:0]      dec_a,
    input  logic [2*NCYC-1:0]      dec_b,
    input  logic [4:0]             mu_shift,
    input  logic [CW-1:0]          conv_thr,
    output logic signed [CW-1:0]   code_out,
    output logic                   out_vld,
    output logic [23:0]            gain_a,
    output logic [23:0]            gain_b,
    output logic [1:0]             mode_a,
    output logic [1:0]             mode_b,
    output logic                   converged
);
    localparam int GW = 24;
    localparam int SW = 24;
    localparam logic [23:0] GMIN = 24'h600000;
    localparam logic [23:0] GMAX = 24'h800000;

    logic signed [CW:0]   sum;
    logic signed [CW:0]   diff;
    logic signed [1:0]    err_sgn;
    logic [GW:0]          step;
    logic signed [SW-1:0] coef_a;
    logic signed [SW-1:0] coef_b;

    // Sum, difference, difference sign and step size.
    always_comb begin
        sum  = (CW+1)'(code_a) + (CW+1)'(code_b);
        diff = (CW+1)'(code_b) - (CW+1)'(code_a);
        if (diff > 0)      err_sgn = 2'sd1;
        else if (diff < 0) err_sgn = -2'sd1;
        else               err_sgn = 2'sd0;
        step = (GW+1)'(1) << mu_shift;
    end

    // Output code register: floor of the mean, plus its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= conv_vld;
            if (conv_vld) code_out <= CW'(sum >>> 1);
        end
    end

    sdk_accum #(.NCYC(NCYC), .G_NOM(G_NOM), .SW(SW)) u_coef_a (
        .dec(dec_a), .coef(coef_a));
    sdk_accum #(.NCYC(NCYC), .G_NOM(G_NOM), .SW(SW)) u_coef_b (
        .dec(dec_b), .coef(coef_b));

    gain_track #(.GW(GW), .SW(SW), .INIT(GA_INIT), .GMIN(GMIN), .GMAX(GMAX), .POL(-1)) u_gain_a (
        .clk(clk), .rst_n(rst_n), .upd(conv_vld), .err_sgn(err_sgn),
        .coef(coef_a), .step(step), .gain(gain_a));
    gain_track #(.GW(GW), .SW(SW), .INIT(GB_INIT), .GMIN(GMIN), .GMAX(GMAX), .POL(1)) u_gain_b (
        .clk(clk), .rst_n(rst_n), .upd(conv_vld), .err_sgn(err_sgn),
        .coef(coef_b), .step(step), .gain(gain_b));

    mode_gen u_modes (
        .clk(clk), .rst_n(rst_n), .upd(conv_vld), .mode_a(mode_a), .mode_b(mode_b));

    run_monitor #(.CW(CW), .RUN(CONV_RUN)) u_run (
        .clk(clk), .rst_n(rst_n), .upd(conv_vld), .diff(diff),
        .thr(conv_thr), .converged(converged));

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        conv_vld |=> out_vld);

    a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_vld |=> !out_vld);

    a_r1_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_vld |=> $stable(code_out));
endmodule

// File: tb/sim_split_gain_cal.sv
module sim_split_gain_cal;
    localparam int CW   = 16;
    localparam int NCYC = 3;
    localparam int GN   = 7864;
    localparam int RUN  = 16;
    localparam int INITG = 24'h7AE148;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_vld = 1'b0;
    logic signed [CW-1:0] code_a = '0;
    logic signed [CW-1:0] code_b = '0;
    logic [2*NCYC-1:0] dec_a = '0;
    logic [2*NCYC-1:0] dec_b = '0;
    logic [4:0] mu_shift = 5'd10;
    logic [CW-1:0] conv_thr = 16'd5;
    logic signed [CW-1:0] code_out;
    logic out_vld;
    logic [23:0] gain_a;
    logic [23:0] gain_b;
    logic [1:0] mode_a;
    logic [1:0] mode_b;
    logic converged;

    int n_chk = 0;
    int n_bad = 0;
    int wts [1:NCYC];
    int ga_m, gb_m;
    logic [1:0] sa_m, sb_m;

    always #5 clk = ~clk;

    split_gain_cal #(.CW(CW), .NCYC(NCYC), .G_NOM(GN), .CONV_RUN(RUN)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .code_a(code_a), .code_b(code_b),
        .dec_a(dec_a), .dec_b(dec_b), .mu_shift(mu_shift), .conv_thr(conv_thr),
        .code_out(code_out), .out_vld(out_vld), .gain_a(gain_a), .gain_b(gain_b),
        .mode_a(mode_a), .mode_b(mode_b), .converged(converged));

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sgn(input longint v);
        return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
    endfunction

    function automatic int dv(input logic [1:0] c);
        return (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
    endfunction

    function automatic int coef(input logic [2*NCYC-1:0] d);
        int s = 0;
        for (int k = 1; k <= NCYC; k++) s += dv(d[2*k-1 -: 2]) * wts[k];
        return s;
    endfunction

    function automatic int clampg(input int g);
        if (g > 24'h800000) return 24'h800000;
        if (g < 24'h600000) return 24'h600000;
        return g;
    endfunction

    function automatic logic [1:0] adv(input logic [1:0] s);
        return {s[0], s[1] ^ s[0]};
    endfunction

    // One conversion: drive at negedge, let one posedge pass, then compare.
    task automatic conv(input int xa, input int xb, input int da, input int db, input int mu);
        int d, st, s;
        code_a = CW'(xa); code_b = CW'(xb);
        dec_a = (2*NCYC)'(da); dec_b = (2*NCYC)'(db);
        mu_shift = 5'(mu); conv_vld = 1'b1;
        d  = xb - xa;
        st = 1 << mu;
        gb_m = clampg(gb_m + st * sgn(d) * sgn(coef(dec_b)));   // R3
        ga_m = clampg(ga_m - st * sgn(d) * sgn(coef(dec_a)));   // R4
        sa_m = adv(sa_m); sb_m = adv(sb_m);
        s = xa + xb;
        @(negedge clk);
        check("R1 vld", out_vld, 1);
        check("R1 code", code_out, s >>> 1);
        check("R3 gain_b", gain_b, gb_m);
        check("R4 gain_a", gain_a, ga_m);
        check("R8 mode_a", mode_a, sa_m);
        check("R8 mode_b", mode_b, (sb_m == sa_m) ? ~sb_m : sb_m);
    endtask

    initial begin
        int p, inv;
        p = 4096; inv = (1 << 24) / GN;
        for (int k = 1; k <= NCYC; k++) begin
            p = int'((longint'(p) * inv) >>> 12);
            wts[k] = k * p;
        end
        ga_m = INITG; gb_m = INITG; sa_m = 2'b01; sb_m = 2'b10;

        repeat (3) @(negedge clk);
        // R10 / R7: reset state
        check("R10 out_vld", out_vld, 0);
        check("R10 converged", converged, 0);
        check("R7 gain_a init", gain_a, INITG);
        check("R7 gain_b init", gain_b, INITG);
        check("R8 reset mode_a", mode_a, 1);
        check("R8 reset mode_b", mode_b, 2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out_vld after reset", out_vld, 0);

        // R2 R3 R4 R5: sweep every decision encoding pair, three difference signs
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                int sel = (i + j) % 3;
                int xa = ((i * 37 + j * 11) % 2000) - 1000;
                int xb = xa + ((sel == 0) ? -3 : ((sel == 1) ? 0 : 2));
                conv(xa, xb, i, j, 10 + ((i + j) % 4));
            end
        end

        // R7: idle cycles leave the gains and modes alone
        conv_vld = 1'b0; code_a = 16'sd300; code_b = -16'sd300; dec_a = 6'b000001; dec_b = 6'b000011;
        repeat (4) @(negedge clk);
        check("R7 hold gain_a", gain_a, ga_m);
        check("R7 hold gain_b", gain_b, gb_m);
        check("R1 idle vld", out_vld, 0);

        // R6: large steps drive both gains to the clamps
        for (int r = 0; r < 3; r++) conv(100, 200, 6'b000001, 6'b000001, 21);
        check("R6 gain_b at max", gain_b, 24'h800000);
        check("R6 gain_a at min", gain_a, 24'h600000);
        for (int r = 0; r < 3; r++) conv(200, 100, 6'b000001, 6'b000001, 21);
        check("R6 gain_b at min", gain_b, 24'h600000);
        check("R6 gain_a at max", gain_a, 24'h800000);

        // R9: convergence after RUN in-threshold conversions, cleared on violation
        conv_thr = 16'd5;
        conv(0, 7, 0, 0, 10);
        for (int r = 0; r < RUN; r++) begin
            conv(r, r + ((r % 2 == 0) ? 4 : -4), 0, 0, 10);
            check("R9 converged run", converged, (r == RUN - 1) ? 1 : 0);
        end
        conv(10, 13, 0, 0, 10);
        check("R9 stays high", converged, 1);
        conv(10, 15, 0, 0, 10);
        check("R9 clear at threshold", converged, 0);

        // R10: reset mid-run
        conv_vld = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R10 converged in reset", converged, 0);
        check("R10 vld in reset", out_vld, 0);
        check("R7 gain_a re-init", gain_a, INITG);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule